// File: doc/BRIEF.md
# Selectable-Fill Right Shifter

This block shifts a data word right by a binary amount through a cascade of multiplexer levels. Level k moves the word by 2^k positions when bit k of the amount is set, and passes it through untouched otherwise. Each level's output feeds the next level. Because the weights are shared this way, an N-bit word needs only log2(N) levels of N two-input selects. A one-per-amount structure would need far more.

A two-bit mode input chooses what enters the vacated upper positions. Logical mode fills them with zeros. Arithmetic mode fills them with copies of the level's top bit. Rotate mode feeds in the bits that fall off the bottom. All three modes share the same selects and differ only in what is wired into the end positions of each level.

A parameter picks between a purely combinational build and a pipelined build with a register after every level. In the pipelined build, the valid flag, the mode and the unused amount bits travel with each word, so back-to-back words with different settings are handled independently.

Top module: `shf_log_shifter`

## Requirements
- R1: The output equals the input shifted right by the unsigned shift amount. Amount bit 0 is worth 1 position, bit 1 is worth 2 and bit 2 is worth 4.
- R2: Mode 2'b00 (logical) fills the vacated upper positions with zeros.
- R3: Mode 2'b01 (arithmetic) fills the vacated upper positions with copies of the input's most significant bit.
- R4: Mode 2'b10 (rotate) feeds the bits shifted out at the bottom back in at the top, so no bit is lost.
- R5: Mode 2'b11 gives exactly the logical result.
- R6: An amount of 0 returns the input unchanged in every mode.
- R7: With PIPELINED=0 the result and out_vld appear in the same cycle as the inputs, and out_vld equals in_vld.
- R8: With PIPELINED=1 every word emerges exactly AMT_W clock cycles after it is presented. One word is accepted per clock, each with its own amount and mode, and out_vld follows in_vld with that same delay.
- R9: With PIPELINED=1, asserting rst_n low clears out_vld at once and keeps it low until words launched after the release arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pipelined build |
| rst_n | input | 1 | Asynchronous active-low reset of the level registers |
| in_vld | input | 1 | Input word is meaningful |
| in_data | input | DATA_W | Word to shift |
| in_amt | input | AMT_W | Unsigned right-shift amount |
| in_mode | input | 2 | Fill select: 00 zero, 01 sign, 10 wrap, 11 zero |
| out_vld | output | 1 | Output word is meaningful |
| out_data | output | DATA_W | Shifted word |

## Verification
The bench instantiates the shifter twice with DATA_W=8: once with PIPELINED=0 and once with PIPELINED=1. Both builds receive the same stream. The 8-bit width makes a complete sweep practical: every data value under every amount and every mode, 8192 words, fed one per clock. This checks every end-fill connection of every level, the 2'b11 fallback, and the pipelined build with settings that change on every word. A reset issued while the pipelined build is full shows that in-flight words are dropped.

// File: rtl/shf_pkg.sv
package shf_pkg;
   typedef enum logic [1:0] {
      FILL_ZERO = 2'b00,
      FILL_SIGN = 2'b01,
      FILL_WRAP = 2'b10,
      FILL_RSVD = 2'b11
   } fill_mode_e;
endpackage

// File: rtl/shf_stage.sv
module shf_stage
   import shf_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int SHIFT  = 1
) (
   input  logic [DATA_W-1:0] din,
   input  logic              en,
   input  logic [1:0]        mode,
   output logic [DATA_W-1:0] dout
);
   if (SHIFT < 1 || SHIFT >= DATA_W) begin : g_bad
      $error("shf_stage: SHIFT must lie in 1..DATA_W-1");
   end

   logic [SHIFT-1:0] fill;

   always_comb begin
      case (fill_mode_e'(mode))
         FILL_SIGN: fill = {SHIFT{din[DATA_W-1]}};
         FILL_WRAP: fill = din[SHIFT-1:0];
         default:   fill = '0;
      endcase
      dout = en ? {fill, din[DATA_W-1:SHIFT]} : din;
   end
endmodule

// File: rtl/shf_hop.sv
module shf_hop #(
   parameter int WIDTH      = 8,
   parameter bit REGISTERED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (REGISTERED) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_wire
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q = d;
   end
endmodule

// File: rtl/shf_log_shifter.sv
module shf_log_shifter #(
   parameter int DATA_W    = 8,
   parameter int AMT_W     = $clog2(DATA_W),
   parameter bit PIPELINED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_data,
   input  logic [AMT_W-1:0]  in_amt,
   input  logic [1:0]        in_mode,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_data
);
   localparam int HOP_W = 1 + 2 + AMT_W + DATA_W;

   if (DATA_W < 2) begin : g_bad_w
      $error("shf_log_shifter: DATA_W must be at least 2");
   end
   if ((1 << AMT_W) != DATA_W) begin : g_bad_amt
      $error("shf_log_shifter: DATA_W must equal 2**AMT_W");
   end

   logic [AMT_W:0][DATA_W-1:0] lvl_data;
   logic [AMT_W:0][AMT_W-1:0]  lvl_amt;
   logic [AMT_W:0][1:0]        lvl_mode;
   logic [AMT_W:0]             lvl_vld;

   assign lvl_data[0] = in_data;
   assign lvl_amt[0]  = in_amt;
   assign lvl_mode[0] = in_mode;
   assign lvl_vld[0]  = in_vld;

   for (genvar k = 0; k < AMT_W; k++) begin : g_lvl
      localparam int SH = 1 << k;
      logic [DATA_W-1:0] shifted;
      logic [HOP_W-1:0]  hop_q;

      shf_stage #(
         .DATA_W(DATA_W),
         .SHIFT (SH)
      ) u_stage (
         .din (lvl_data[k]),
         .en  (lvl_amt[k][k]),
         .mode(lvl_mode[k]),
         .dout(shifted)
      );

      shf_hop #(
         .WIDTH     (HOP_W),
         .REGISTERED(PIPELINED)
      ) u_hop (
         .clk  (clk),
         .rst_n(rst_n),
         .d    ({lvl_vld[k], lvl_mode[k], lvl_amt[k], shifted}),
         .q    (hop_q)
      );

      assign lvl_data[k+1] = hop_q[DATA_W-1:0];
      assign lvl_amt[k+1]  = hop_q[DATA_W +: AMT_W];
      assign lvl_mode[k+1] = hop_q[DATA_W+AMT_W +: 2];
      assign lvl_vld[k+1]  = hop_q[HOP_W-1];
   end

   logic unused_tail;
   assign unused_tail = ^{lvl_amt[AMT_W], lvl_mode[AMT_W]};

   assign out_data = lvl_data[AMT_W];
   assign out_vld  = lvl_vld[AMT_W];
endmodule

// File: rtl/shf_chk.sv
module shf_chk #(
   parameter int DATA_W    = 8,
   parameter int AMT_W     = 3,
   parameter bit PIPELINED = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_vld,
   input logic [DATA_W-1:0] in_data,
   input logic [AMT_W-1:0]  in_amt,
   input logic [1:0]        in_mode,
   input logic              out_vld,
   input logic [DATA_W-1:0] out_data
);
   localparam int H_W = 1 + 2 + AMT_W + DATA_W;
   localparam int LAT = PIPELINED ? AMT_W : 0;

   logic [H_W-1:0] cur_h, dly_h;
   assign cur_h = {in_vld, in_mode, in_amt, in_data};

   if (LAT == 0) begin : g_nodly
      assign dly_h = cur_h;
   end else begin : g_dly
      logic [LAT-1:0][H_W-1:0] line;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line <= '0;
         else        line <= {line[LAT-2:0], cur_h};
      end
      assign dly_h = line[LAT-1];
   end

   logic [DATA_W-1:0] d_data;
   logic [AMT_W-1:0]  d_amt;
   logic [1:0]        d_mode;
   logic              d_vld;
   assign {d_vld, d_mode, d_amt, d_data} = dly_h;

   // R7 R8 R9: valid tracks input valid with the build's latency
   p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == d_vld);

   p_zero_amt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (d_vld && d_amt == '0) |-> out_data == d_data);

   p_logical_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (d_vld && (d_mode == 2'b00 || d_mode == 2'b11) && d_amt != '0)
      |-> !out_data[DATA_W-1]);

   p_arith_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (d_vld && d_mode == 2'b01) |-> out_data[DATA_W-1] == d_data[DATA_W-1]);

   p_rotate_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (d_vld && d_mode == 2'b10) |-> $countones(out_data) == $countones(d_data));
endmodule

bind shf_log_shifter shf_chk #(
   .DATA_W   (DATA_W),
   .AMT_W    (AMT_W),
   .PIPELINED(PIPELINED)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .in_vld  (in_vld),
   .in_data (in_data),
   .in_amt  (in_amt),
   .in_mode (in_mode),
   .out_vld (out_vld),
   .out_data(out_data)
);

// File: tb/tb_shf_log_shifter.sv
module tb_shf_log_shifter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_vld = 1'b0;
   logic [7:0] in_data = '0;
   logic [2:0] in_amt = '0;
   logic [1:0] in_mode = '0;
   logic       p_vld, c_vld;
   logic [7:0] p_data, c_data;
   int         checks = 0;
   int         fails = 0;
   logic       h_vld [3];
   logic [7:0] h_exp [3];
   string      h_tag [3];

   always #10 clk = ~clk;

   shf_log_shifter #(.DATA_W(8), .AMT_W(3), .PIPELINED(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
      .in_amt(in_amt), .in_mode(in_mode), .out_vld(p_vld), .out_data(p_data));

   shf_log_shifter #(.DATA_W(8), .AMT_W(3), .PIPELINED(1'b0)) dut_comb (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
      .in_amt(in_amt), .in_mode(in_mode), .out_vld(c_vld), .out_data(c_data));

   function automatic logic [7:0] model(input logic [7:0] d, input int a, input int m);
      logic [15:0] two;
      two = {d, d} >> a;
      case (m)
         1:       return 8'($signed(d) >>> a);
         2:       return two[7:0];
         default: return d >> a;
      endcase
   endfunction

   function automatic string tag_of(input int a, input int m);
      if (a == 0) return "R6";
      case (m)
         0: return "R1/R2";
         1: return "R1/R3";
         2: return "R1/R4";
         default: return "R5";
      endcase
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_hist();
      for (int i = 0; i < 3; i++) begin
         h_vld[i] = 1'b0; h_exp[i] = '0; h_tag[i] = "R8";
      end
   endtask

   // called at a negedge, before new inputs are driven
   task automatic check_pipe();
      check("R8 valid", {7'd0, p_vld}, {7'd0, h_vld[2]});
      if (h_vld[2]) check({h_tag[2], " pipelined R8"}, p_data, h_exp[2]);
   endtask

   task automatic push(input logic v, input logic [7:0] d, input int a, input int m);
      h_vld[2] = h_vld[1]; h_exp[2] = h_exp[1]; h_tag[2] = h_tag[1];
      h_vld[1] = h_vld[0]; h_exp[1] = h_exp[0]; h_tag[1] = h_tag[0];
      h_vld[0] = v; h_exp[0] = model(d, a, m); h_tag[0] = tag_of(a, m);
      in_vld = v; in_data = d; in_amt = 3'(a); in_mode = 2'(m);
      #1;
      check("R7 valid", {7'd0, c_vld}, {7'd0, v});
      check({tag_of(a, m), " comb R7"}, c_data, model(d, a, m));
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog R8 actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      clear_hist();
      in_vld = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 reset", {7'd0, p_vld}, 8'd0);
      in_vld = 1'b0;
      rst_n = 1'b1;

      for (int m = 0; m < 4; m++)
         for (int a = 0; a < 8; a++)
            for (int d = 0; d < 256; d++) begin
               @(negedge clk);
               check_pipe();
               push(((d + a + m) % 5) != 4, 8'(d), a, m);
            end
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check_pipe();
         push(1'b0, 8'h00, 0, 0);
      end

      // reset while the pipelined build holds valid words
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         check_pipe();
         push(1'b1, 8'hA5, 1, 2);
      end
      @(negedge clk);
      in_vld = 1'b0;
      rst_n = 1'b0;
      #1;
      check("R9 flush", {7'd0, p_vld}, 8'd0);
      @(negedge clk);
      check("R9 hold", {7'd0, p_vld}, 8'd0);
      rst_n = 1'b1;
      clear_hist();
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check_pipe();
         push(1'b0, 8'h00, 0, 0);
      end

      summary();
      $finish;
   end
endmodule